// File: doc/BRIEF.md
# Operand Address and Stack Branch Sequencer

This block sits between the decoder and the datapath of a register-workspace CPU. It turns an addressing-mode code, a register number and an operand size into an operand effective address. It writes back the pointer register when the mode moves the pointer. Post-increment and pre-decrement are paired, so any general register can act as the stack pointer of its own stack. Double-indirect addressing is sequenced in hardware: one memory read fetches the final operand address.

Two control-flow operations are sequenced on the same datapath. Link-push pre-decrements a chosen stack register, stores a return address at the new top of that stack, and then loads the PC with an immediate target. Indirect-jump loads the PC with the word read at the effective address. With the indexed mode this acts as a jump-table dispatch. With post-increment on a stack register it acts as a return. The register file and memory are outside the block. Registers are read combinationally. The single register write port is shared with the datapath's operand write, and memory is reached through a request/ready port.

Top module: `opaddr_gen`

## Requirements
- R1: While reset is applied and in the cycles after it, `busy`, `done`, `mem_req`, `rf_wr_en` and `pc_load` are all 0.
- R2: Address mode 0 (register direct) raises `done` one cycle after `start`, with `ea_is_reg`=1, `ea` equal to the register number, and no register or memory access.
- R3: Mode 1 (indirect) and the reserved modes 6 and 7 give `ea` = R. Mode 5 (indexed) gives `ea` = R + `disp`. All of them finish one cycle after `start` and write no register.
- R4: Mode 2 (post-increment) gives `ea` = R and writes R + step back into R in the `done` cycle. The step is 1, 2 or 4 for `size` 0, 1 or 2, and `size` 3 also steps by 4.
- R5: Mode 3 (pre-decrement) gives `ea` = R − step and writes that same value back into R in the `done` cycle.
- R6: Mode 4 (double-indirect) makes one memory read at address R and returns the read word as `ea`. R is left unchanged.
- R7: While `mem_ready` is low, `mem_req`, `mem_addr` and `mem_we` stay constant. A memory phase that waits L cycles delays `done` by exactly L cycles.
- R8: Operation 1 (link-push) writes R − AW/8 into stack register R one cycle after `start`. It writes `ret_addr` to memory at R − AW/8, reports that address as `ea`, and pulses `pc_load` with `done` and `pc_new` = `target` in the cycle after the write is accepted.
- R9: Operation 2 (indirect-jump) reads memory at the mode's effective address and sets `pc_new` to the read word. With mode 0 it sets `pc_new` = R and makes no memory access. With mode 4 it makes two reads. With mode 2 on a stack register it pops the word most recently pushed there. `pc_load` is only ever high together with `done`.
- R10: A pointer writeback has priority on the register write port. In that cycle `opw_ready` is 0, and a pending operand write to the same register lands one cycle later, so the operand value is the one that remains.
- R11: A `start` that arrives while `busy` is high is ignored.
- R12: Several registers can each serve as an independent stack: pushes and pops on different registers, interleaved, return each stack's own values in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 2 | 0 address, 1 link-push, 2 indirect-jump, 3 treated as address |
| mode | input | 3 | Addressing mode code |
| rsel | input | RW | Register number (stack register for link-push) |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| disp | input | AW | Displacement for indexed mode |
| target | input | AW | Branch target for link-push |
| ret_addr | input | AW | Return address stored by link-push |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| ea | output | AW | Effective address (register number when `ea_is_reg`) |
| ea_is_reg | output | 1 | Operand is the register itself |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | AW | New PC value |
| rf_rd_idx | output | RW | Register read index |
| rf_rd_data | input | AW | Register read data |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_idx | output | RW | Register write index |
| rf_wr_data | output | AW | Register write data |
| opw_valid | input | 1 | Datapath operand write request |
| opw_idx | input | RW | Operand write register |
| opw_data | input | AW | Operand write data |
| opw_ready | output | 1 | Operand write accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | AW | Memory write data |
| mem_rdata | input | AW | Memory read data |
| mem_ready | input | 1 | Memory access completes this cycle |

## Verification
A post-increment pointer writeback and the datapath's operand write to the same register can fall in the same cycle. The bench provokes this by raising `opw_valid` for the stepped register in the exact `done` cycle of a post-increment, and again for a different register. It then judges the result at the ports: `opw_ready` must be low in that cycle. The register must hold the stepped pointer one cycle later and the operand value after that. Link-push, pops and double reads are also run under memory wait states of 0 to 2 cycles, while a second `start` is raised mid-operation.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  typedef enum logic [2:0] {
    AM_REG  = 3'd0,
    AM_IND  = 3'd1,
    AM_PINC = 3'd2,
    AM_PDEC = 3'd3,
    AM_DIND = 3'd4,
    AM_IDX  = 3'd5,
    AM_RSV6 = 3'd6,
    AM_RSV7 = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    OP_ADDR = 2'd0,
    OP_LPUSH = 2'd1,
    OP_IJMP = 2'd2,
    OP_RSV  = 2'd3
  } opk_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDP  = 2'd1,
    ST_RDT  = 2'd2,
    ST_PUSH = 2'd3
  } st_e;
endpackage

// File: rtl/opaddr_step.sv
module opaddr_step #(
  parameter int AW = 16
) (
  input  logic [1:0]    size,
  output logic [AW-1:0] step
);
  always_comb begin
    unique case (size)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end
endmodule

// File: rtl/opaddr_calc.sv
module opaddr_calc #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic [2:0]    mode,
  input  logic [RW-1:0] ridx,
  input  logic [AW-1:0] pval,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] ea,
  output logic          is_reg,
  output logic          upd,
  output logic [AW-1:0] newp,
  output logic          dind
);
  import opaddr_pkg::*;

  always_comb begin
    ea     = pval;
    is_reg = 1'b0;
    upd    = 1'b0;
    newp   = pval;
    dind   = 1'b0;
    case (amode_e'(mode))
      AM_REG: begin
        ea     = AW'(ridx);
        is_reg = 1'b1;
      end
      AM_PINC: begin
        upd  = 1'b1;
        newp = pval + step;
      end
      AM_PDEC: begin
        ea   = pval - step;
        upd  = 1'b1;
        newp = pval - step;
      end
      AM_DIND: dind = 1'b1;
      AM_IDX:  ea = pval + disp;
      default: ea = pval;
    endcase
  end
endmodule

// File: rtl/opaddr_wrmux.sv
module opaddr_wrmux #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          ptr_wr,
  input  logic [RW-1:0] ptr_idx,
  input  logic [AW-1:0] ptr_val,
  input  logic          opw_valid,
  input  logic [RW-1:0] opw_idx,
  input  logic [AW-1:0] opw_data,
  output logic          opw_ready,
  output logic          rf_wr_en,
  output logic [RW-1:0] rf_wr_idx,
  output logic [AW-1:0] rf_wr_data
);
  assign opw_ready  = ~ptr_wr;
  assign rf_wr_en   = ptr_wr | opw_valid;
  assign rf_wr_idx  = ptr_wr ? ptr_idx : opw_idx;
  assign rf_wr_data = ptr_wr ? ptr_val : opw_data;
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int AW   = 16,
  parameter int NREG = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               op,
  input  logic [2:0]               mode,
  input  logic [$clog2(NREG)-1:0]  rsel,
  input  logic [1:0]               size,
  input  logic [AW-1:0]            disp,
  input  logic [AW-1:0]            target,
  input  logic [AW-1:0]            ret_addr,
  output logic                     busy,
  output logic                     done,
  output logic [AW-1:0]            ea,
  output logic                     ea_is_reg,
  output logic                     pc_load,
  output logic [AW-1:0]            pc_new,
  output logic [$clog2(NREG)-1:0]  rf_rd_idx,
  input  logic [AW-1:0]            rf_rd_data,
  output logic                     rf_wr_en,
  output logic [$clog2(NREG)-1:0]  rf_wr_idx,
  output logic [AW-1:0]            rf_wr_data,
  input  logic                     opw_valid,
  input  logic [$clog2(NREG)-1:0]  opw_idx,
  input  logic [AW-1:0]            opw_data,
  output logic                     opw_ready,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [AW-1:0]            mem_wdata,
  input  logic [AW-1:0]            mem_rdata,
  input  logic                     mem_ready
);
  import opaddr_pkg::*;

  localparam int RW     = $clog2(NREG);
  localparam int ABYTES = AW / 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // state registers and their next values
  st_e           state_q, state_d;
  logic [AW-1:0] ea_q, ea_d, addr_q, addr_d, wdata_q, wdata_d, pc_q, pc_d;
  logic [AW-1:0] pval_q, pval_d;
  logic [RW-1:0] pidx_q, pidx_d;
  logic          isreg_q, isreg_d, done_q, done_d, pcld_q, pcld_d;
  logic          pwr_q, pwr_d, ij_q, ij_d;

  // combinational helpers
  logic [AW-1:0] step, c_ea, c_newp, p;
  logic          c_isreg, c_upd, c_dind, accept;

  assign rf_rd_idx = rsel;
  assign p         = rf_rd_data;
  assign accept    = start && (state_q == ST_IDLE);

  opaddr_step #(.AW(AW)) u_step (
    .size (size),
    .step (step)
  );

  opaddr_calc #(.AW(AW), .RW(RW)) u_calc (
    .mode   (mode),
    .ridx   (rsel),
    .pval   (p),
    .disp   (disp),
    .step   (step),
    .ea     (c_ea),
    .is_reg (c_isreg),
    .upd    (c_upd),
    .newp   (c_newp),
    .dind   (c_dind)
  );

  opaddr_wrmux #(.AW(AW), .RW(RW)) u_wrmux (
    .ptr_wr     (pwr_q),
    .ptr_idx    (pidx_q),
    .ptr_val    (pval_q),
    .opw_valid  (opw_valid),
    .opw_idx    (opw_idx),
    .opw_data   (opw_data),
    .opw_ready  (opw_ready),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_idx  (rf_wr_idx),
    .rf_wr_data (rf_wr_data)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    ea_d    = ea_q;
    isreg_d = isreg_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    pc_d    = pc_q;
    pidx_d  = pidx_q;
    pval_d  = pval_q;
    ij_d    = ij_q;
    done_d  = 1'b0;
    pcld_d  = 1'b0;
    pwr_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          pidx_d = rsel;
          if (opk_e'(op) == OP_LPUSH) begin
            pwr_d   = 1'b1;
            pval_d  = p - AW'(ABYTES);
            addr_d  = p - AW'(ABYTES);
            ea_d    = p - AW'(ABYTES);
            isreg_d = 1'b0;
            wdata_d = ret_addr;
            pc_d    = target;
            state_d = ST_PUSH;
          end else begin
            pwr_d   = c_upd;
            pval_d  = c_newp;
            ea_d    = c_ea;
            isreg_d = c_isreg;
            ij_d    = (opk_e'(op) == OP_IJMP);
            if (c_dind) begin
              addr_d  = p;
              state_d = ST_RDP;
            end else if (opk_e'(op) == OP_IJMP) begin
              if (c_isreg) begin
                pc_d   = p;
                pcld_d = 1'b1;
                done_d = 1'b1;
              end else begin
                addr_d  = c_ea;
                state_d = ST_RDT;
              end
            end else begin
              done_d = 1'b1;
            end
          end
        end
      end
      ST_RDP: begin
        if (mem_ready) begin
          ea_d = mem_rdata;
          if (ij_q) begin
            addr_d  = mem_rdata;
            state_d = ST_RDT;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_RDT: begin
        if (mem_ready) begin
          pc_d    = mem_rdata;
          pcld_d  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: begin
        if (mem_ready) begin
          pcld_d  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      isreg_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      pc_q    <= '0;
      pidx_q  <= '0;
      pval_q  <= '0;
      ij_q    <= 1'b0;
      done_q  <= 1'b0;
      pcld_q  <= 1'b0;
      pwr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ea_q    <= ea_d;
      isreg_q <= isreg_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      pc_q    <= pc_d;
      pidx_q  <= pidx_d;
      pval_q  <= pval_d;
      ij_q    <= ij_d;
      done_q  <= done_d;
      pcld_q  <= pcld_d;
      pwr_q   <= pwr_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ea        = ea_q;
  assign ea_is_reg = isreg_q;
  assign pc_load   = pcld_q;
  assign pc_new    = pc_q;
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_PUSH);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8
  push_then_branch_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && mem_we && mem_ready) |=> (pc_load && done));

  // R9
  ijmp_pc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_RDT && mem_ready) |=> (pc_load && pc_new == $past(mem_rdata)));

  // R9
  pcload_with_done_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pc_load |-> done);

  // R4
  ptr_wr_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pwr_q |-> $past(accept));

  // R11
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);
endmodule

// File: tb/opaddr_gen_test.sv
`timescale 1ns/1ps
module opaddr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [2:0]  mode;
  logic [3:0]  rsel;
  logic [1:0]  size;
  logic [15:0] disp, target, ret_addr;
  logic        busy, done, ea_is_reg, pc_load;
  logic [15:0] ea, pc_new;
  logic [3:0]  rf_rd_idx, rf_wr_idx, opw_idx;
  logic [15:0] rf_rd_data, rf_wr_data, opw_data;
  logic        rf_wr_en, opw_valid, opw_ready;
  logic        mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  int lat = 0;
  int wcnt = 0;

  logic [15:0] regs [16];
  logic [15:0] mem_m [256];
  logic        mem_v [256];

  always #2 clk = ~clk;

  opaddr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode), .rsel(rsel),
    .size(size), .disp(disp), .target(target), .ret_addr(ret_addr),
    .busy(busy), .done(done), .ea(ea), .ea_is_reg(ea_is_reg),
    .pc_load(pc_load), .pc_new(pc_new),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .opw_valid(opw_valid), .opw_idx(opw_idx), .opw_data(opw_data), .opw_ready(opw_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [15:0] memval(input logic [15:0] a);
    if (mem_v[a[8:1]]) return mem_m[a[8:1]];
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  assign rf_rd_data = regs[rf_rd_idx];
  assign mem_ready  = mem_req && (wcnt == lat);
  always_comb mem_rdata = memval(mem_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 16'(16'h1000 + i * 16'h0111);
      for (int i = 0; i < 256; i++) begin mem_v[i] <= 1'b0; mem_m[i] <= '0; end
      wcnt <= 0;
    end else begin
      if (rf_wr_en) begin regs[rf_wr_idx] <= rf_wr_data; wr_cnt <= wr_cnt + 1; end
      if (mem_req && mem_we && mem_ready) begin
        mem_m[mem_addr[8:1]] <= mem_wdata;
        mem_v[mem_addr[8:1]] <= 1'b1;
      end
      if (mem_req && !mem_ready) wcnt <= wcnt + 1;
      else wcnt <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] o, input logic [2:0] m, input logic [3:0] r,
                        input logic [1:0] s, input logic [15:0] d, input logic [15:0] t,
                        input logic [15:0] ra);
    op = o; mode = m; rsel = r; size = s; disp = d; target = t; ret_addr = ra;
    start = 1'b1;
  endtask

  task automatic wait_done(output int n);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin @(negedge clk); n++; end
  endtask

  task automatic run(input logic [1:0] o, input logic [2:0] m, input logic [3:0] r,
                     input logic [1:0] s, input logic [15:0] d, input logic [15:0] t,
                     input logic [15:0] ra, output int n);
    launch(o, m, r, s, d, t, ra);
    wait_done(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog act=running exp=finished");
    bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, w0;
    logic [15:0] p, stp, exp_ea, exp_r, v1, v2, a1, a2;
    rst_n = 1'b0; start = 1'b0; op = '0; mode = '0; rsel = '0; size = '0;
    disp = '0; target = '0; ret_addr = '0; opw_valid = 1'b0; opw_idx = '0; opw_data = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy && !done && !mem_req && !rf_wr_en && !pc_load, "R1 in reset",
          {busy, done, mem_req, rf_wr_en, pc_load}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !mem_req && !rf_wr_en && !pc_load, "R1 after reset",
          {busy, done, mem_req, rf_wr_en, pc_load}, 0);

    // address-mode sweep: sizes x modes x wait states x registers
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int l = 0; l < 3; l++) begin
          for (int k = 0; k < 3; k++) begin
            logic [3:0] r;
            r = (k == 0) ? 4'd0 : (k == 1) ? 4'd5 : 4'd15;
            lat = l;
            p = regs[r];
            stp = (s == 0) ? 16'd1 : (s == 1) ? 16'd2 : 16'd4;
            exp_r = p;
            case (m)
              0: exp_ea = {12'd0, r};
              2: begin exp_ea = p; exp_r = p + stp; end
              3: begin exp_ea = p - stp; exp_r = p - stp; end
              4: exp_ea = memval(p);
              5: exp_ea = p + 16'h0246;
              default: exp_ea = p;
            endcase
            w0 = wr_cnt;
            run(2'd0, 3'(m), r, 2'(s), 16'h0246, 16'h0, 16'h0, n);
            if (m == 0) begin
              check(ea == exp_ea && ea_is_reg, "R2 direct ea", {ea_is_reg, ea}, {1'b1, exp_ea});
              check(n == 1, "R2 direct latency", n, 1);
            end else if (m == 2) begin
              check(ea == exp_ea && !ea_is_reg, "R4 post-inc ea", ea, exp_ea);
            end else if (m == 3) begin
              check(ea == exp_ea && !ea_is_reg, "R5 pre-dec ea", ea, exp_ea);
            end else if (m == 4) begin
              check(ea == exp_ea, "R6 double-indirect ea", ea, exp_ea);
              check(n == 2 + l, "R7 double-indirect wait", n, 2 + l);
            end else begin
              check(ea == exp_ea && !ea_is_reg && n == 1, "R3 indirect/indexed ea", ea, exp_ea);
            end
            check(!pc_load, "R9 no pc_load for address op", pc_load, 0);
            @(negedge clk);
            check(regs[r] == exp_r, (m == 2) ? "R4 post-inc reg" : (m == 3) ? "R5 pre-dec reg" :
                  "R3 R6 reg unchanged", regs[r], exp_r);
            check((wr_cnt - w0) == ((m == 2 || m == 3) ? 1 : 0), "R2 R3 write count",
                  wr_cnt - w0, (m == 2 || m == 3) ? 1 : 0);
          end
        end
      end
    end

    // link-push then pop via indirect-jump post-increment, per wait state
    for (int l = 0; l < 3; l++) begin
      lat = l;
      p = regs[6];
      run(2'd1, 3'd0, 4'd6, 2'd1, 16'h0, 16'h4400 + 16'(l), 16'h2220 + 16'(l), n);
      check(pc_load && pc_new == 16'h4400 + 16'(l), "R8 push branch target", pc_new, 16'h4400 + 16'(l));
      check(ea == p - 16'd2, "R8 push address", ea, p - 16'd2);
      check(n == 2 + l, "R8 R7 push wait", n, 2 + l);
      @(negedge clk);
      check(regs[6] == p - 16'd2, "R8 stack reg", regs[6], p - 16'd2);
      check(memval(p - 16'd2) == 16'h2220 + 16'(l), "R8 pushed word", memval(p - 16'd2), 16'h2220 + 16'(l));
      run(2'd2, 3'd2, 4'd6, 2'd1, 16'h0, 16'h0, 16'h0, n);
      check(pc_load && pc_new == 16'h2220 + 16'(l), "R9 pop return", pc_new, 16'h2220 + 16'(l));
      check(n == 2 + l, "R9 R7 pop wait", n, 2 + l);
      @(negedge clk);
      check(regs[6] == p, "R9 pop restores stack reg", regs[6], p);
    end

    // indirect-jump: direct, indexed table, double-indirect
    lat = 1;
    p = regs[2];
    run(2'd2, 3'd0, 4'd2, 2'd1, 16'h0, 16'h0, 16'h0, n);
    check(pc_load && pc_new == p && n == 1, "R9 direct jump", pc_new, p);
    @(negedge clk);
    run(2'd2, 3'd5, 4'd2, 2'd1, 16'h0006, 16'h0, 16'h0, n);
    check(pc_load && pc_new == memval(p + 16'h0006), "R9 table dispatch", pc_new, memval(p + 16'h0006));
    @(negedge clk);
    exp_ea = memval(memval(p));
    run(2'd2, 3'd4, 4'd2, 2'd1, 16'h0, 16'h0, 16'h0, n);
    check(pc_load && pc_new == exp_ea, "R9 double-indirect jump", pc_new, exp_ea);
    check(n == 5, "R9 R7 two-read wait", n, 5);
    @(negedge clk);

    // R12 interleaved independent stacks
    lat = 0;
    a1 = regs[4]; a2 = regs[9];
    run(2'd1, 3'd0, 4'd4, 2'd1, 16'h0, 16'h0100, 16'hAAA1, n); @(negedge clk);
    run(2'd1, 3'd0, 4'd9, 2'd1, 16'h0100, 16'h0100, 16'hBBB2, n); @(negedge clk);
    run(2'd1, 3'd0, 4'd4, 2'd1, 16'h0, 16'h0100, 16'hCCC3, n); @(negedge clk);
    run(2'd2, 3'd2, 4'd4, 2'd1, 16'h0, 16'h0, 16'h0, n); v1 = pc_new; @(negedge clk);
    check(v1 == 16'hCCC3, "R12 stack A top", v1, 16'hCCC3);
    run(2'd2, 3'd2, 4'd9, 2'd1, 16'h0, 16'h0, 16'h0, n); v2 = pc_new; @(negedge clk);
    check(v2 == 16'hBBB2, "R12 stack B top", v2, 16'hBBB2);
    run(2'd2, 3'd2, 4'd4, 2'd1, 16'h0, 16'h0, 16'h0, n); v1 = pc_new; @(negedge clk);
    check(v1 == 16'hAAA1, "R12 stack A bottom", v1, 16'hAAA1);
    check(regs[4] == a1 && regs[9] == a2, "R12 stack regs restored", {regs[4], regs[9]}, {a1, a2});

    // R10 same-register collision
    p = regs[3];
    run(2'd0, 3'd2, 4'd3, 2'd1, 16'h0, 16'h0, 16'h0, n);
    opw_valid = 1'b1; opw_idx = 4'd3; opw_data = 16'hBEEF;
    #0.5;
    check(!opw_ready, "R10 operand write held", opw_ready, 0);
    @(negedge clk);
    check(regs[3] == p + 16'd2, "R10 pointer committed first", regs[3], p + 16'd2);
    check(opw_ready, "R10 operand write accepted next", opw_ready, 1);
    @(negedge clk);
    opw_valid = 1'b0;
    check(regs[3] == 16'hBEEF, "R10 operand value remains", regs[3], 16'hBEEF);
    // R10 different-register collision
    p = regs[8];
    run(2'd0, 3'd3, 4'd8, 2'd2, 16'h0, 16'h0, 16'h0, n);
    opw_valid = 1'b1; opw_idx = 4'd11; opw_data = 16'h1234;
    #0.5;
    check(!opw_ready, "R10 other-register write held", opw_ready, 0);
    @(negedge clk);
    @(negedge clk);
    opw_valid = 1'b0;
    check(regs[8] == p - 16'd4 && regs[11] == 16'h1234, "R10 both writes land",
          {regs[8], regs[11]}, {p - 16'd4, 16'h1234});

    // R11 start while busy is ignored
    lat = 2;
    p = regs[7];
    launch(2'd1, 3'd0, 4'd1, 2'd1, 16'h0, 16'h3000, 16'h5555);
    @(negedge clk);
    launch(2'd0, 3'd3, 4'd7, 2'd1, 16'h0, 16'h0, 16'h0);
    @(negedge clk);
    start = 1'b0;
    n = 2;
    while (!done && n < 60) begin @(negedge clk); n++; end
    check(pc_new == 16'h3000 && n == 4, "R11 first op completes", {16'(n), pc_new}, {16'd4, 16'h3000});
    @(negedge clk);
    check(!done && regs[7] == p, "R11 second start ignored", {done, regs[7]}, {1'b0, p});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule